// File: doc/BRIEF.md
# Paged Descriptor Ring Address Generator

This block produces the memory addresses of descriptors in three circular rings: a request ring that the host fills and the block consumes, a completion ring and a message ring that the block fills for the host. Every ring is spread over a table of separate memory pages. Each slot address is the base of the page holding that slot plus the slot's offset inside the page. The block keeps one running pointer per ring. It checks that pointer against indices coming from the host-side register logic, and it answers each pop strobe one cycle later with the next slot address, or with a miss.

Software first loads page numbers into the page tables. It then starts a data-ring setup that gives the page counts of the request and completion rings. After that it may start a message-ring setup. A ring holds the page count times 32 entries, rounded up to a power of two. The block publishes the log2 of each ring length and, on flush strobes, the indices the host reads back. A clear strobe returns the block to its reset state.

Top module: `desc_ring_agu`

## Requirements
- R1: After reset or a `ringClear` pulse, all published indices, all log2 outputs, `cfgDone`, `cfgOk`, the hit flags and the addresses are zero, and no ring counts as set up.
- R2: `cfgDataGo` is accepted only when both page counts lie in 1..32. `cfgDone` is high in the cycle after the strobe and `cfgOk` shows acceptance. On acceptance, `reqLog2` and `cmpLog2` become the bit length of (count×32−1), and the request and completion pointers and their published indices become 0.
- R3: `cfgMsgGo` (ignored while `cfgDataGo` is high) is accepted only when the count lies in 1..32 and a data setup was accepted earlier. On acceptance, `msgLog2` is set the same way and the message pointer and `msgProdIdx` become 0.
- R4: A slot address is computed in three steps. First m = pointer AND (2^log2−1). Then the page is m/32 and the offset is m mod 32. The address is (page-table entry[page] shifted left by 12) + offset × D, where D is 128 for the request ring, 32 for the completion ring and 64 for the message ring.
- R5: A request pop hits only when the data rings are set up, `hostReqProd` ≠ pointer, and (`hostReqProd` − pointer) mod 2^32 < 1024. A hit returns the address of the current pointer and then increments the pointer. A miss returns address 0 and leaves the pointer unchanged.
- R6: A completion pop has no overflow check. It always returns the address of the current fill pointer and increments the pointer, so it wraps through the masked index.
- R7: A message pop hits only when the message ring is set up and (`msgProdIdx` − `hostMsgCons`) mod 2^32 < 2^`msgLog2`. A hit increments the pointer. A miss returns address 0.
- R8: A flush strobe publishes the pointer as it stood before the same edge's pop: the request pointer goes to `reqConsIdx`, the completion pointer to `cmpProdIdx`, and the message pointer to `msgProdIdx`. Without a flush, clear or accepted setup, the published index holds its value.
- R9: Priority is clear first, then an accepted setup, then pops and flushes. Pops and flushes of a ring in the cycle of an accepted setup of that ring, or in the cycle of a clear, are dropped: the pop misses, with address 0. Setup strobes during a clear give no `cfgDone`.
- R10: `reqRsp`, `cmpRsp` and `msgRsp` are high exactly in the cycle after the matching pop strobe.
- R11: `ptWrEn` writes `ptWrPpn` into page slot `ptWrSlot` of the ring coded by `ptWrRing` (0 request, 1 completion, 2 message). A pop in the same cycle sees the old entry, and a clear zeroes every table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ringClear | input | 1 | Synchronous return to reset state |
| ptWrEn | input | 1 | Page-table write strobe |
| ptWrRing | input | 2 | Ring code of the write |
| ptWrSlot | input | 5 | Page slot of the write |
| ptWrPpn | input | 32 | Page number written |
| cfgDataGo | input | 1 | Data-ring setup strobe |
| cfgReqPages | input | 6 | Request ring page count |
| cfgCmpPages | input | 6 | Completion ring page count |
| cfgMsgGo | input | 1 | Message-ring setup strobe |
| cfgMsgPages | input | 6 | Message ring page count |
| cfgDone | output | 1 | Setup answered |
| cfgOk | output | 1 | Setup accepted |
| hostReqProd | input | 32 | Host request producer index |
| hostMsgCons | input | 32 | Host message consumer index |
| reqPop | input | 1 | Request pop strobe |
| reqRsp | output | 1 | Request pop answer |
| reqHit | output | 1 | Request descriptor available |
| reqAddr | output | 44 | Request descriptor address |
| cmpPop | input | 1 | Completion pop strobe |
| cmpRsp | output | 1 | Completion pop answer |
| cmpAddr | output | 44 | Completion slot address |
| msgPop | input | 1 | Message pop strobe |
| msgRsp | output | 1 | Message pop answer |
| msgHit | output | 1 | Message slot available |
| msgAddr | output | 44 | Message slot address |
| reqFlush | input | 1 | Publish request pointer |
| cmpFlush | input | 1 | Publish completion pointer |
| msgFlush | input | 1 | Publish message pointer |
| reqConsIdx | output | 32 | Published request consumer index |
| cmpProdIdx | output | 32 | Published completion producer index |
| msgProdIdx | output | 32 | Published message producer index |
| reqLog2 | output | 4 | Request ring log2 length |
| cmpLog2 | output | 4 | Completion ring log2 length |
| msgLog2 | output | 4 | Message ring log2 length |

## Verification
A pointer that has drifted shows up at the next hit on that ring, one cycle after the pop, as a wrong address. A bad page-table entry only shows when the pointer's masked index reaches that page. A bad mask shows only once a ring wraps, so the stimulus runs each ring past its length. A wrong validity flag or room comparison turns a hit into a miss, or a miss into a hit, on the next pop. A stale pointer surfaces at the published index one cycle after a flush.

// File: rtl/descring_pkg.sv
package descring_pkg;

  // Strobes from control to datapath, already prioritised and gated.
  typedef struct packed {
    logic clearAll;
    logic loadData;
    logic loadMsg;
    logic popReq;
    logic popCmp;
    logic popMsg;
    logic flushReq;
    logic flushCmp;
    logic flushMsg;
  } ringStrobes_t;

  // Number of significant bits in v (0 for v == 0).
  function automatic int unsigned bitLen(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n = i + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/ring_ctl.sv
module ring_ctl
  import descring_pkg::*;
#(
  parameter int unsigned MAX_PAGES = 32,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ringClear,
  input  logic             cfgDataGo,
  input  logic [CNT_W-1:0] cfgReqPages,
  input  logic [CNT_W-1:0] cfgCmpPages,
  input  logic             cfgMsgGo,
  input  logic [CNT_W-1:0] cfgMsgPages,
  input  logic             reqPop,
  input  logic             cmpPop,
  input  logic             msgPop,
  input  logic             reqFlush,
  input  logic             cmpFlush,
  input  logic             msgFlush,
  input  logic             reqAvail,
  input  logic             msgRoom,
  output ringStrobes_t     strb,
  output logic             cfgDone,
  output logic             cfgOk,
  output logic             reqRsp,
  output logic             reqHit,
  output logic             cmpRsp,
  output logic             msgRsp,
  output logic             msgHit
);

  logic dataValid, msgValid;
  logic dataOk, msgOk, accData, accMsg;

  function automatic logic inRange(input logic [CNT_W-1:0] c);
    return (c != '0) && (c <= CNT_W'(MAX_PAGES));
  endfunction

  always_comb begin
    dataOk  = inRange(cfgReqPages) && inRange(cfgCmpPages);
    msgOk   = inRange(cfgMsgPages) && dataValid;
    accData = !ringClear && cfgDataGo && dataOk;
    accMsg  = !ringClear && !cfgDataGo && cfgMsgGo && msgOk;

    strb          = '0;
    strb.clearAll = ringClear;
    strb.loadData = accData;
    strb.loadMsg  = accMsg;
    strb.popReq   = !ringClear && !accData && reqPop && dataValid && reqAvail;
    strb.popCmp   = !ringClear && !accData && cmpPop;
    strb.popMsg   = !ringClear && !accMsg && msgPop && msgValid && msgRoom;
    strb.flushReq = !ringClear && !accData && reqFlush;
    strb.flushCmp = !ringClear && !accData && cmpFlush;
    strb.flushMsg = !ringClear && !accMsg && msgFlush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      msgValid  <= 1'b0;
      cfgDone   <= 1'b0;
      cfgOk     <= 1'b0;
      reqRsp    <= 1'b0;
      reqHit    <= 1'b0;
      cmpRsp    <= 1'b0;
      msgRsp    <= 1'b0;
      msgHit    <= 1'b0;
    end else begin
      if (ringClear) begin
        dataValid <= 1'b0;
        msgValid  <= 1'b0;
      end else begin
        if (accData) dataValid <= 1'b1;
        if (accMsg)  msgValid  <= 1'b1;
      end
      cfgDone <= !ringClear && (cfgDataGo || cfgMsgGo);
      cfgOk   <= accData || accMsg;
      reqRsp  <= reqPop;
      reqHit  <= strb.popReq;
      cmpRsp  <= cmpPop;
      msgRsp  <= msgPop;
      msgHit  <= strb.popMsg;
    end
  end

endmodule

// File: rtl/ring_dp.sv
module ring_dp
  import descring_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned EPP        = 32,
  parameter int unsigned MAX_PAGES  = 32,
  parameter int unsigned PPN_W      = 32,
  parameter int unsigned IDX_W      = 32,
  parameter int unsigned REQ_DESC_B = 128,
  parameter int unsigned CMP_DESC_B = 32,
  parameter int unsigned MSG_DESC_B = 64,
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned PG_W       = 5,
  parameter int unsigned LOG_W      = 4,
  parameter int unsigned ADDR_W     = 44
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobes_t      strb,
  input  logic              ptWrEn,
  input  logic [1:0]        ptWrRing,
  input  logic [PG_W-1:0]   ptWrSlot,
  input  logic [PPN_W-1:0]  ptWrPpn,
  input  logic [CNT_W-1:0]  cfgReqPages,
  input  logic [CNT_W-1:0]  cfgCmpPages,
  input  logic [CNT_W-1:0]  cfgMsgPages,
  input  logic [IDX_W-1:0]  hostReqProd,
  input  logic [IDX_W-1:0]  hostMsgCons,
  output logic              reqAvail,
  output logic              msgRoom,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] cmpAddr,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [IDX_W-1:0]  reqConsIdx,
  output logic [IDX_W-1:0]  cmpProdIdx,
  output logic [IDX_W-1:0]  msgProdIdx,
  output logic [LOG_W-1:0]  reqLog2,
  output logic [LOG_W-1:0]  cmpLog2,
  output logic [LOG_W-1:0]  msgLog2
);

  localparam int unsigned NRING   = 3;
  localparam int unsigned MAX_ENT = MAX_PAGES * EPP;
  localparam int unsigned EPP_LOG = $clog2(EPP);
  localparam int unsigned MIDX_W  = EPP_LOG + PG_W;

  logic [PPN_W-1:0]  pageTab [NRING][MAX_PAGES];
  logic [IDX_W-1:0]  ptr     [NRING];
  logic [IDX_W-1:0]  pub     [NRING];
  logic [LOG_W-1:0]  lenLog  [NRING];
  logic [ADDR_W-1:0] slotAddr[NRING];

  function automatic logic [LOG_W-1:0] ringLog(input logic [CNT_W-1:0] pages);
    return LOG_W'(bitLen(32'(pages) * 32'(EPP) - 32'd1));
  endfunction

  // One address generator per ring; only the descriptor size differs.
  for (genvar r = 0; r < NRING; r++) begin : g_ring
    localparam int unsigned DB = (r == 0) ? REQ_DESC_B : (r == 1) ? CMP_DESC_B : MSG_DESC_B;
    logic [MIDX_W:0]   lenMask;
    logic [MIDX_W-1:0] mIdx;
    logic [PG_W-1:0]   pageSel;
    logic [EPP_LOG-1:0] inPage;
    always_comb begin
      lenMask     = ((MIDX_W+1)'(1) << lenLog[r]) - (MIDX_W+1)'(1);
      mIdx        = ptr[r][MIDX_W-1:0] & lenMask[MIDX_W-1:0];
      pageSel     = mIdx[MIDX_W-1:EPP_LOG];
      inPage      = mIdx[EPP_LOG-1:0];
      slotAddr[r] = {pageTab[r][pageSel], {PAGE_SHIFT{1'b0}}}
                  + ADDR_W'(inPage) * ADDR_W'(DB);
    end
  end

  logic [IDX_W-1:0] reqGap, msgGap, msgLen;
  always_comb begin
    reqGap   = hostReqProd - ptr[0];
    reqAvail = (hostReqProd != ptr[0]) && (reqGap < IDX_W'(MAX_ENT));
    msgGap   = pub[2] - hostMsgCons;
    msgLen   = IDX_W'(1) << msgLog2;
    msgRoom  = msgGap < msgLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NRING; r++) begin
        ptr[r]    <= '0;
        pub[r]    <= '0;
        lenLog[r] <= '0;
        for (int p = 0; p < MAX_PAGES; p++) pageTab[r][p] <= '0;
      end
    end else if (strb.clearAll) begin
      for (int r = 0; r < NRING; r++) begin
        ptr[r]    <= '0;
        pub[r]    <= '0;
        lenLog[r] <= '0;
        for (int p = 0; p < MAX_PAGES; p++) pageTab[r][p] <= '0;
      end
    end else begin
      if (ptWrEn && (ptWrRing != 2'd3)) pageTab[ptWrRing][ptWrSlot] <= ptWrPpn;
      if (strb.flushReq) pub[0] <= ptr[0];
      if (strb.flushCmp) pub[1] <= ptr[1];
      if (strb.flushMsg) pub[2] <= ptr[2];
      if (strb.popReq)   ptr[0] <= ptr[0] + 1'b1;
      if (strb.popCmp)   ptr[1] <= ptr[1] + 1'b1;
      if (strb.popMsg)   ptr[2] <= ptr[2] + 1'b1;
      if (strb.loadData) begin
        lenLog[0] <= ringLog(cfgReqPages);
        lenLog[1] <= ringLog(cfgCmpPages);
        ptr[0] <= '0;
        ptr[1] <= '0;
        pub[0] <= '0;
        pub[1] <= '0;
      end
      if (strb.loadMsg) begin
        lenLog[2] <= ringLog(cfgMsgPages);
        ptr[2] <= '0;
        pub[2] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr <= '0;
      cmpAddr <= '0;
      msgAddr <= '0;
    end else begin
      reqAddr <= strb.popReq ? slotAddr[0] : '0;
      cmpAddr <= strb.popCmp ? slotAddr[1] : '0;
      msgAddr <= strb.popMsg ? slotAddr[2] : '0;
    end
  end

  always_comb begin
    reqConsIdx = pub[0];
    cmpProdIdx = pub[1];
    msgProdIdx = pub[2];
    reqLog2    = lenLog[0];
    cmpLog2    = lenLog[1];
    msgLog2    = lenLog[2];
  end

endmodule

// File: rtl/desc_ring_agu.sv
module desc_ring_agu
  import descring_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned EPP        = 32,
  parameter int unsigned MAX_PAGES  = 32,
  parameter int unsigned PPN_W      = 32,
  parameter int unsigned IDX_W      = 32,
  parameter int unsigned REQ_DESC_B = 128,
  parameter int unsigned CMP_DESC_B = 32,
  parameter int unsigned MSG_DESC_B = 64,
  localparam int unsigned ADDR_W    = PPN_W + PAGE_SHIFT,
  localparam int unsigned PG_W      = $clog2(MAX_PAGES),
  localparam int unsigned CNT_W     = $clog2(MAX_PAGES + 1),
  localparam int unsigned LOG_W     = $clog2($clog2(MAX_PAGES * EPP) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ringClear,
  input  logic              ptWrEn,
  input  logic [1:0]        ptWrRing,
  input  logic [PG_W-1:0]   ptWrSlot,
  input  logic [PPN_W-1:0]  ptWrPpn,
  input  logic              cfgDataGo,
  input  logic [CNT_W-1:0]  cfgReqPages,
  input  logic [CNT_W-1:0]  cfgCmpPages,
  input  logic              cfgMsgGo,
  input  logic [CNT_W-1:0]  cfgMsgPages,
  output logic              cfgDone,
  output logic              cfgOk,
  input  logic [IDX_W-1:0]  hostReqProd,
  input  logic [IDX_W-1:0]  hostMsgCons,
  input  logic              reqPop,
  output logic              reqRsp,
  output logic              reqHit,
  output logic [ADDR_W-1:0] reqAddr,
  input  logic              cmpPop,
  output logic              cmpRsp,
  output logic [ADDR_W-1:0] cmpAddr,
  input  logic              msgPop,
  output logic              msgRsp,
  output logic              msgHit,
  output logic [ADDR_W-1:0] msgAddr,
  input  logic              reqFlush,
  input  logic              cmpFlush,
  input  logic              msgFlush,
  output logic [IDX_W-1:0]  reqConsIdx,
  output logic [IDX_W-1:0]  cmpProdIdx,
  output logic [IDX_W-1:0]  msgProdIdx,
  output logic [LOG_W-1:0]  reqLog2,
  output logic [LOG_W-1:0]  cmpLog2,
  output logic [LOG_W-1:0]  msgLog2
);

  ringStrobes_t strb;
  logic reqAvail, msgRoom;

  ring_ctl #(.MAX_PAGES(MAX_PAGES), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ringClear(ringClear),
    .cfgDataGo(cfgDataGo), .cfgReqPages(cfgReqPages), .cfgCmpPages(cfgCmpPages),
    .cfgMsgGo(cfgMsgGo), .cfgMsgPages(cfgMsgPages),
    .reqPop(reqPop), .cmpPop(cmpPop), .msgPop(msgPop),
    .reqFlush(reqFlush), .cmpFlush(cmpFlush), .msgFlush(msgFlush),
    .reqAvail(reqAvail), .msgRoom(msgRoom), .strb(strb),
    .cfgDone(cfgDone), .cfgOk(cfgOk),
    .reqRsp(reqRsp), .reqHit(reqHit), .cmpRsp(cmpRsp),
    .msgRsp(msgRsp), .msgHit(msgHit)
  );

  ring_dp #(
    .PAGE_SHIFT(PAGE_SHIFT), .EPP(EPP), .MAX_PAGES(MAX_PAGES), .PPN_W(PPN_W),
    .IDX_W(IDX_W), .REQ_DESC_B(REQ_DESC_B), .CMP_DESC_B(CMP_DESC_B),
    .MSG_DESC_B(MSG_DESC_B), .CNT_W(CNT_W), .PG_W(PG_W), .LOG_W(LOG_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ptWrEn(ptWrEn), .ptWrRing(ptWrRing), .ptWrSlot(ptWrSlot), .ptWrPpn(ptWrPpn),
    .cfgReqPages(cfgReqPages), .cfgCmpPages(cfgCmpPages), .cfgMsgPages(cfgMsgPages),
    .hostReqProd(hostReqProd), .hostMsgCons(hostMsgCons),
    .reqAvail(reqAvail), .msgRoom(msgRoom),
    .reqAddr(reqAddr), .cmpAddr(cmpAddr), .msgAddr(msgAddr),
    .reqConsIdx(reqConsIdx), .cmpProdIdx(cmpProdIdx), .msgProdIdx(msgProdIdx),
    .reqLog2(reqLog2), .cmpLog2(cmpLog2), .msgLog2(msgLog2)
  );

endmodule

// File: rtl/desc_ring_agu_chk.sv
module desc_ring_agu_chk #(
  parameter int unsigned MAX_PAGES = 32,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned IDX_W     = 32,
  parameter int unsigned ADDR_W    = 44,
  parameter int unsigned LOG_W     = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ringClear,
  input logic              cfgDataGo,
  input logic              cfgMsgGo,
  input logic [CNT_W-1:0]  cfgReqPages,
  input logic              cfgDone,
  input logic              cfgOk,
  input logic              reqPop,
  input logic              reqRsp,
  input logic              reqHit,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              cmpPop,
  input logic              cmpRsp,
  input logic              msgPop,
  input logic              msgRsp,
  input logic              msgHit,
  input logic [ADDR_W-1:0] msgAddr,
  input logic              reqFlush,
  input logic [IDX_W-1:0]  reqConsIdx,
  input logic [IDX_W-1:0]  cmpProdIdx,
  input logic [IDX_W-1:0]  msgProdIdx,
  input logic [LOG_W-1:0]  reqLog2
);

  a_r10_req_rsp: assert property (@(posedge clk) disable iff (!rstN) reqPop |=> reqRsp);
  a_r10_req_quiet: assert property (@(posedge clk) disable iff (!rstN) !reqPop |=> !reqRsp);
  a_r10_cmp_rsp: assert property (@(posedge clk) disable iff (!rstN) cmpPop |=> cmpRsp);
  a_r10_msg_rsp: assert property (@(posedge clk) disable iff (!rstN) msgPop |=> msgRsp);
  a_r5_miss_null: assert property (@(posedge clk) disable iff (!rstN)
    (reqRsp && !reqHit) |-> (reqAddr == '0));
  a_r7_miss_null: assert property (@(posedge clk) disable iff (!rstN)
    (msgRsp && !msgHit) |-> (msgAddr == '0));
  a_r2_done: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDataGo && !ringClear) |=> cfgDone);
  a_r2_reject: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDataGo && ((cfgReqPages == '0) || (cfgReqPages > CNT_W'(MAX_PAGES)))) |=> !cfgOk);
  a_r2_ok_needs_done: assert property (@(posedge clk) disable iff (!rstN) cfgOk |-> cfgDone);
  a_r1_clear: assert property (@(posedge clk) disable iff (!rstN)
    ringClear |=> (reqConsIdx == '0 && cmpProdIdx == '0 && msgProdIdx == '0 && reqLog2 == '0));
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    ringClear |=> (!cfgDone && !reqHit && !msgHit));
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!reqFlush && !ringClear && !cfgDataGo) |=> $stable(reqConsIdx));
  a_r3_msg_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDataGo && !cfgMsgGo) |=> !cfgDone);

endmodule

bind desc_ring_agu desc_ring_agu_chk #(
  .MAX_PAGES(MAX_PAGES), .CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LOG_W(LOG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .ringClear(ringClear), .cfgDataGo(cfgDataGo),
  .cfgMsgGo(cfgMsgGo), .cfgReqPages(cfgReqPages), .cfgDone(cfgDone), .cfgOk(cfgOk),
  .reqPop(reqPop), .reqRsp(reqRsp), .reqHit(reqHit), .reqAddr(reqAddr),
  .cmpPop(cmpPop), .cmpRsp(cmpRsp), .msgPop(msgPop), .msgRsp(msgRsp),
  .msgHit(msgHit), .msgAddr(msgAddr), .reqFlush(reqFlush),
  .reqConsIdx(reqConsIdx), .cmpProdIdx(cmpProdIdx), .msgProdIdx(msgProdIdx),
  .reqLog2(reqLog2)
);

// File: tb/test_desc_ring_agu.sv
module test_desc_ring_agu;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ringClear = 0, ptWrEn = 0;
  logic [1:0] ptWrRing = 0;
  logic [4:0] ptWrSlot = 0;
  logic [31:0] ptWrPpn = 0;
  logic cfgDataGo = 0, cfgMsgGo = 0;
  logic [5:0] cfgReqPages = 0, cfgCmpPages = 0, cfgMsgPages = 0;
  logic [31:0] hostReqProd = 0, hostMsgCons = 0;
  logic reqPop = 0, cmpPop = 0, msgPop = 0;
  logic reqFlush = 0, cmpFlush = 0, msgFlush = 0;
  logic cfgDone, cfgOk, reqRsp, reqHit, cmpRsp, msgRsp, msgHit;
  logic [43:0] reqAddr, cmpAddr, msgAddr;
  logic [31:0] reqConsIdx, cmpProdIdx, msgProdIdx;
  logic [3:0] reqLog2, cmpLog2, msgLog2;

  always #2 clk = ~clk;

  desc_ring_agu i_desc_ring_agu (.*);

  int nChecks = 0, nFails = 0;

  // Behavioural reference model state.
  logic [31:0] mTab [3][32];
  logic [31:0] mPtr [3];
  logic [31:0] mPub [3];
  int          mLg  [3];
  bit          mDataV, mMsgV;
  bit eDone, eOk, eReqRsp, eReqHit, eCmpRsp, eMsgRsp, eMsgHit;
  logic [43:0] eReqAddr, eCmpAddr, eMsgAddr;
  int descSize [3] = '{128, 32, 64};

  function automatic int lenBits(logic [31:0] v);
    int n = 0;
    while (n < 32 && (v >> n) != 0) n++;
    return n;
  endfunction

  function automatic bit legal(logic [5:0] c);
    return c >= 1 && c <= 32;
  endfunction

  function automatic logic [43:0] refAddr(int r, logic [31:0] p);
    longint unsigned m, page, off;
    m = p % (64'd1 << mLg[r]);
    page = m / 32;
    off = m % 32;
    return 44'(longint'(mTab[r][page]) * 4096 + off * descSize[r]);
  endfunction

  task automatic modelZero();
    for (int r = 0; r < 3; r++) begin
      mPtr[r] = 0; mPub[r] = 0; mLg[r] = 0;
      for (int p = 0; p < 32; p++) mTab[r][p] = 0;
    end
    mDataV = 0; mMsgV = 0;
  endtask

  // Computes the outputs expected after the coming clock edge.
  task automatic modelStep();
    bit accD, accM, rh, cp, mh;
    logic [31:0] gap, oldPtr [3];
    if (!rstN) begin
      modelZero();
      {eDone, eOk, eReqRsp, eReqHit, eCmpRsp, eMsgRsp, eMsgHit} = '0;
      eReqAddr = 0; eCmpAddr = 0; eMsgAddr = 0;
      return;
    end
    eReqRsp = reqPop; eCmpRsp = cmpPop; eMsgRsp = msgPop;
    if (ringClear) begin
      modelZero();
      {eDone, eOk, eReqHit, eMsgHit} = '0;
      eReqAddr = 0; eCmpAddr = 0; eMsgAddr = 0;
      return;
    end
    accD = cfgDataGo && legal(cfgReqPages) && legal(cfgCmpPages);
    accM = !cfgDataGo && cfgMsgGo && legal(cfgMsgPages) && mDataV;
    eDone = cfgDataGo || cfgMsgGo;
    eOk = accD || accM;
    gap = hostReqProd - mPtr[0];
    rh = reqPop && mDataV && !accD && hostReqProd != mPtr[0] && gap < 1024;
    cp = cmpPop && !accD;
    gap = mPub[2] - hostMsgCons;
    mh = msgPop && mMsgV && !accM && (longint'(gap) < (longint'(1) << mLg[2]));
    eReqHit = rh; eMsgHit = mh;
    eReqAddr = rh ? refAddr(0, mPtr[0]) : 0;
    eCmpAddr = cp ? refAddr(1, mPtr[1]) : 0;
    eMsgAddr = mh ? refAddr(2, mPtr[2]) : 0;
    oldPtr = mPtr;
    if (reqFlush && !accD) mPub[0] = oldPtr[0];
    if (cmpFlush && !accD) mPub[1] = oldPtr[1];
    if (msgFlush && !accM) mPub[2] = oldPtr[2];
    if (rh) mPtr[0]++;
    if (cp) mPtr[1]++;
    if (mh) mPtr[2]++;
    if (accD) begin
      mLg[0] = lenBits(cfgReqPages * 32 - 1);
      mLg[1] = lenBits(cfgCmpPages * 32 - 1);
      mPtr[0] = 0; mPtr[1] = 0; mPub[0] = 0; mPub[1] = 0; mDataV = 1;
    end
    if (accM) begin
      mLg[2] = lenBits(cfgMsgPages * 32 - 1);
      mPtr[2] = 0; mPub[2] = 0; mMsgV = 1;
    end
    if (ptWrEn && ptWrRing != 3) mTab[ptWrRing][ptWrSlot] = ptWrPpn;
  endtask

  task automatic chk(string rq, string nm, logic [63:0] got, logic [63:0] exp, string ph);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s [%s]: actual %h expected %h", rq, nm, ph, got, exp);
    end
  endtask

  task automatic compareAll(string ph);
    chk("R10", "reqRsp", 64'(reqRsp), 64'(eReqRsp), ph);
    chk("R5", "reqHit", 64'(reqHit), 64'(eReqHit), ph);
    chk("R4", "reqAddr", 64'(reqAddr), 64'(eReqAddr), ph);
    chk("R10", "cmpRsp", 64'(cmpRsp), 64'(eCmpRsp), ph);
    chk("R6", "cmpAddr", 64'(cmpAddr), 64'(eCmpAddr), ph);
    chk("R10", "msgRsp", 64'(msgRsp), 64'(eMsgRsp), ph);
    chk("R7", "msgHit", 64'(msgHit), 64'(eMsgHit), ph);
    chk("R4", "msgAddr", 64'(msgAddr), 64'(eMsgAddr), ph);
    chk("R2", "cfgDone", 64'(cfgDone), 64'(eDone), ph);
    chk("R2", "cfgOk", 64'(cfgOk), 64'(eOk), ph);
    chk("R8", "reqConsIdx", 64'(reqConsIdx), 64'(mPub[0]), ph);
    chk("R8", "cmpProdIdx", 64'(cmpProdIdx), 64'(mPub[1]), ph);
    chk("R8", "msgProdIdx", 64'(msgProdIdx), 64'(mPub[2]), ph);
    chk("R2", "reqLog2", 64'(reqLog2), 64'(mLg[0]), ph);
    chk("R2", "cmpLog2", 64'(cmpLog2), 64'(mLg[1]), ph);
    chk("R3", "msgLog2", 64'(msgLog2), 64'(mLg[2]), ph);
  endtask

  task automatic quiet();
    {ringClear, ptWrEn, cfgDataGo, cfgMsgGo, reqPop, cmpPop, msgPop,
     reqFlush, cmpFlush, msgFlush} = '0;
  endtask

  task automatic tick(string ph);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll(ph);
    quiet();
  endtask

  task automatic wrPage(logic [1:0] r, logic [4:0] s, logic [31:0] p, string ph);
    ptWrEn = 1; ptWrRing = r; ptWrSlot = s; ptWrPpn = p;
    tick(ph);
  endtask

  task automatic dataSetup(logic [5:0] rq, logic [5:0] cq, string ph);
    cfgDataGo = 1; cfgReqPages = rq; cfgCmpPages = cq;
    tick(ph);
  endtask

  task automatic msgSetup(logic [5:0] n, string ph);
    cfgMsgGo = 1; cfgMsgPages = n;
    tick(ph);
  endtask

  bit finished = 0;

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick("R1 reset");
    rstN = 1;
    tick("R1 after reset");

    // R11: page tables for all three rings
    for (int s = 0; s < 4; s++) wrPage(2'd0, 5'(s), 32'h100 + s, "R11 req table");
    for (int s = 0; s < 2; s++) wrPage(2'd1, 5'(s), 32'h200 + s, "R11 cmp table");
    for (int s = 0; s < 2; s++) wrPage(2'd2, 5'(s), 32'h300 + s, "R11 msg table");

    // R5: request pop before any setup misses
    hostReqProd = 5; reqPop = 1; tick("R5 before setup");
    // R3: message setup before data setup is refused
    msgSetup(6'd2, "R3 no data rings");
    // R2: out-of-range counts refused, then a good setup
    dataSetup(6'd0, 6'd1, "R2 zero pages");
    dataSetup(6'd33, 6'd1, "R2 too many pages");
    dataSetup(6'd3, 6'd34, "R2 cmp too many");
    dataSetup(6'd3, 6'd1, "R2 accept");

    // R5: five entries available, sixth pop misses
    for (int i = 0; i < 6; i++) begin reqPop = 1; tick("R5 drain"); end
    reqFlush = 1; tick("R8 req flush");

    // R5: distance boundary at the maximum ring size
    hostReqProd = mPtr[0] + 1024; reqPop = 1; tick("R5 gap 1024 misses");
    hostReqProd = mPtr[0] + 1023; reqPop = 1; tick("R5 gap 1023 hits");
    // R4: run past the rounded ring length to wrap the mask
    for (int i = 0; i < 140; i++) begin reqPop = 1; tick("R4 req wrap"); end
    // R8: flush with a same-cycle pop publishes the old pointer
    reqPop = 1; reqFlush = 1; tick("R8 flush with pop");

    // R6: completion ring wraps without overflow check
    for (int i = 0; i < 40; i++) begin cmpPop = 1; tick("R6 cmp wrap"); end
    cmpFlush = 1; cmpPop = 1; tick("R8 cmp flush");

    // R3/R7: message ring
    msgSetup(6'd0, "R3 zero pages");
    msgSetup(6'd2, "R3 accept");
    hostMsgCons = 0;
    for (int i = 0; i < 3; i++) begin msgPop = 1; tick("R7 msg pop"); end
    msgFlush = 1; tick("R8 msg flush");
    hostMsgCons = mPub[2] - 64; msgPop = 1; tick("R7 full ring misses");
    hostMsgCons = mPub[2] - 63; msgPop = 1; tick("R7 one free hits");

    // R9: pops dropped in the cycle of an accepted setup
    cfgDataGo = 1; cfgReqPages = 1; cfgCmpPages = 2;
    hostReqProd = 4; reqPop = 1; cmpPop = 1; reqFlush = 1; tick("R9 setup wins");
    cfgMsgGo = 1; cfgMsgPages = 1; msgPop = 1; tick("R9 msg setup wins");
    // R9: clear beats everything
    ringClear = 1; cfgDataGo = 1; cfgReqPages = 1; cfgCmpPages = 1;
    reqPop = 1; cmpPop = 1; msgPop = 1; tick("R9 clear priority");
    // R1: state after clear
    reqPop = 1; cmpPop = 1; tick("R1 after clear");
    // R11: tables were zeroed by the clear
    dataSetup(6'd1, 6'd1, "R11 setup after clear");
    hostReqProd = 1; reqPop = 1; cmpPop = 1; tick("R11 zero tables");

    // Mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      ptWrEn = ($urandom % 6) == 0;
      ptWrRing = 2'($urandom); ptWrSlot = 5'($urandom); ptWrPpn = $urandom;
      cfgDataGo = ($urandom % 50) == 0;
      cfgReqPages = 6'($urandom % 35); cfgCmpPages = 6'($urandom % 35);
      cfgMsgGo = ($urandom % 40) == 0;
      cfgMsgPages = 6'($urandom % 35);
      ringClear = ($urandom % 400) == 0;
      reqPop = $urandom % 2; cmpPop = $urandom % 2; msgPop = $urandom % 2;
      reqFlush = ($urandom % 5) == 0; cmpFlush = ($urandom % 5) == 0;
      msgFlush = ($urandom % 5) == 0;
      if (($urandom % 20) == 0) hostReqProd = $urandom;
      else if (($urandom % 10) == 0) hostReqProd = mPtr[0] + ($urandom % 40);
      if (($urandom % 10) == 0) hostMsgCons = mPub[2] - ($urandom % 600);
      tick("R4 R5 R6 R7 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule